// File: doc/BRIEF.md
# Opcode Fetch and Memory Read Bus Sequencer with Built-in Row Refresh

This block produces the external bus timing of an 8-bit processor that has separate address and data buses. A request names the cycle type (opcode fetch or data read) and the address. The block then runs either a four-clock fetch cycle or a three-clock read cycle. In both cycle types the memory request and read strobes are held low for the first two clocks, so memory gets the same access window either way. A dedicated machine-cycle-one strobe marks fetch cycles only. The byte on the data bus is captured at the clock edge that ends the second clock.

A fetch does not end when its opcode is captured. During its last two clocks the address bus carries a refresh address and a refresh strobe is low, so dynamic memory is refreshed without any external logic. The refresh address has three parts. The upper byte comes from a page register. The next bit is a held bit. The low seven bits are a row counter that advances once per fetch. The memory request strobe is pulsed again for one clock during refresh, and the read strobe stays high.

The sequencer has eight states. IDLE waits. FETCH_T1, FETCH_T2, FETCH_T3 and FETCH_T4 make up a fetch, and READ_T1, READ_T2 and READ_T3 make up a read. The transitions are as follows. IDLE goes to FETCH_T1 or READ_T1 when a request arrives, and otherwise stays in IDLE. Each T state advances to the next one in its cycle. FETCH_T4 and READ_T3 are the last states of their cycles: each goes to FETCH_T1 or READ_T1 if a request is present, and to IDLE if not. This lets cycles run back to back.

Top module: `fetch_bus_seq`

## Requirements
- R1: While reset is low, and on the first clock after it is released, m1_n, mreq_n, rd_n and rfsh_n are 1, data_valid is 0 and addr_out is 0. Reset also clears the row counter, so the first refresh after reset drives row 0. Reset clears the page register and the held bit as well.
- R2: start is sampled only in IDLE, FETCH_T4 or READ_T3. When it is sampled high, T1 of the requested cycle appears in the next clock, and addr_out carries the addr_in value that was present at that edge. If start is high in any other state, it has no effect on the outputs.
- R3: A fetch (is_fetch=1) lasts exactly 4 clocks. In T1 and T2, addr_out is the requested address and m1_n, mreq_n and rd_n are all 0.
- R4: data_in is captured at the edge that ends T2 of both fetch and read cycles. data_out holds that byte until the next capture. data_valid is 1 only during T3 of a fetch or of a read.
- R5: In fetch T3 and T4, rfsh_n is 0 and m1_n and rd_n are 1. mreq_n is 0 in T3 and 1 in T4.
- R6: The refresh address bits [6:0] are a 7-bit row counter. The counter advances by one at the end of every fetch and wraps from 127 to 0. Read cycles leave it unchanged.
- R7: A read (is_fetch=0) lasts exactly 3 clocks. In T1 and T2, mreq_n and rd_n are 0 and m1_n is 1. In T3 all strobes are 1 and addr_out still carries the requested address.
- R8: The refresh address bits [15:8] come from a page register and bit [7] comes from a held bit. Both are loaded from page_din and msb_din on a clock edge where page_we is 1, and they never change otherwise.
- R9: In IDLE all strobes are 1, and addr_out and data_out keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Cycle request, sampled in IDLE or in the last T state |
| is_fetch | input | 1 | 1 selects opcode fetch, 0 selects data read |
| addr_in | input | 16 | Address of the requested cycle |
| data_in | input | 8 | Data bus from memory |
| page_we | input | 1 | Load enable for the refresh page register and held bit |
| page_din | input | 8 | New refresh page (upper address byte) |
| msb_din | input | 1 | New held bit for refresh address bit 7 |
| addr_out | output | 16 | Address bus |
| m1_n | output | 1 | Machine-cycle-one strobe, active low |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| data_out | output | 8 | Captured data or opcode byte |
| data_valid | output | 1 | data_out was captured in this cycle's T2 |

## Verification
The bench runs single fetches and single reads from IDLE, which separate the 4-clock fetch timing from the 3-clock read timing. It also runs fetch-to-fetch, fetch-to-read, read-to-fetch and read-to-read pairs back to back; these show whether the last-state transitions skip IDLE correctly. A request is raised in the middle of a cycle to show that it is ignored. A run of 130 fetches takes the row counter through its wrap from 127 to 0. The page and the held bit are changed during that run, which shows whether each refresh address field comes from the right source. The data bus changes every clock, so a capture one edge early or one edge late gives a different byte.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_F1,
        ST_F2,
        ST_F3,
        ST_F4,
        ST_R1,
        ST_R2,
        ST_R3
    } bus_state_t;
endpackage

// File: rtl/fbs_seq.sv
module fbs_seq
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_fetch,
    output logic       take,
    output logic       cap,
    output logic       row_step,
    output logic       in_rfsh,
    output logic       m1_n,
    output logic       mreq_n,
    output logic       rd_n,
    output logic       rfsh_n,
    output logic       data_valid
);
    bus_state_t state, state_nx;
    logic       at_end;

    always_comb begin
        at_end = (state == ST_IDLE) || (state == ST_F4) || (state == ST_R3);
        take   = at_end && start;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_F4, ST_R3: begin
                if (start) state_nx = is_fetch ? ST_F1 : ST_R1;
                else       state_nx = ST_IDLE;
            end
            ST_F1: state_nx = ST_F2;
            ST_F2: state_nx = ST_F3;
            ST_F3: state_nx = ST_F4;
            ST_R1: state_nx = ST_R2;
            ST_R2: state_nx = ST_R3;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        m1_n       = 1'b1;
        mreq_n     = 1'b1;
        rd_n       = 1'b1;
        rfsh_n     = 1'b1;
        data_valid = 1'b0;
        cap        = 1'b0;
        row_step   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_F1: begin
                m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
            end
            ST_F2: begin
                m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; cap = 1'b1;
            end
            ST_F3: begin
                mreq_n = 1'b0; rfsh_n = 1'b0; data_valid = 1'b1;
            end
            ST_F4: begin
                rfsh_n = 1'b0; row_step = 1'b1;
            end
            ST_R1: begin
                mreq_n = 1'b0; rd_n = 1'b0;
            end
            ST_R2: begin
                mreq_n = 1'b0; rd_n = 1'b0; cap = 1'b1;
            end
            ST_R3: data_valid = 1'b1;
            default: ;
        endcase
        in_rfsh = !rfsh_n;
    end
endmodule

// File: rtl/fbs_refresh_ctr.sv
module fbs_refresh_ctr #(
    parameter int PAGE_W = 8,
    parameter int ROW_W  = 7,
    localparam int AW    = PAGE_W + 1 + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              msb_din,
    output logic [AW-1:0]     rfsh_addr
);
    logic [PAGE_W-1:0] page_q;
    logic              msb_q;
    logic [ROW_W-1:0]  row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            msb_q  <= 1'b0;
        end else if (page_we) begin
            page_q <= page_din;
            msb_q  <= msb_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    row_q <= '0;
        else if (step) row_q <= row_q + 1'b1;
    end

    assign rfsh_addr = {page_q, msb_q, row_q};
endmodule

// File: rtl/fbs_latch.sv
module fbs_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/fetch_bus_seq.sv
module fetch_bus_seq #(
    parameter int PAGE_W = 8,
    parameter int ROW_W  = 7,
    parameter int DATA_W = 8,
    localparam int AW    = PAGE_W + 1 + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_fetch,
    input  logic [AW-1:0]     addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              msb_din,
    output logic [AW-1:0]     addr_out,
    output logic              m1_n,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              rfsh_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid
);
    logic          take, cap, row_step, in_rfsh;
    logic [AW-1:0] addr_q, rfsh_addr;

    fbs_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .is_fetch   (is_fetch),
        .take       (take),
        .cap        (cap),
        .row_step   (row_step),
        .in_rfsh    (in_rfsh),
        .m1_n       (m1_n),
        .mreq_n     (mreq_n),
        .rd_n       (rd_n),
        .rfsh_n     (rfsh_n),
        .data_valid (data_valid)
    );

    fbs_refresh_ctr #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_rfsh (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (row_step),
        .page_we   (page_we),
        .page_din  (page_din),
        .msb_din   (msb_din),
        .rfsh_addr (rfsh_addr)
    );

    fbs_latch #(.W(AW)) u_addr (
        .clk (clk), .rst_n (rst_n), .en (take), .d (addr_in), .q (addr_q)
    );

    fbs_latch #(.W(DATA_W)) u_data (
        .clk (clk), .rst_n (rst_n), .en (cap), .d (data_in), .q (data_out)
    );

    assign addr_out = in_rfsh ? rfsh_addr : addr_q;
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk (
    input logic clk,
    input logic rst_n,
    input logic m1_n,
    input logic mreq_n,
    input logic rd_n,
    input logic rfsh_n,
    input logic data_valid
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (m1_n && mreq_n && rd_n && rfsh_n && !data_valid)
                else $error("strobes active during reset");
        end
    end

    p_m1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m1_n) |=> !m1_n);

    p_m1_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n && $past(!m1_n)) |=> m1_n);

    p_rfsh_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (rd_n && m1_n));

    p_rfsh_mreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_n) |-> !mreq_n);

    p_rfsh_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_n) |=> (mreq_n && !rfsh_n));

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> !rd_n);

    p_valid_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> ($past(!rd_n) && rd_n));
endmodule

bind fetch_bus_seq fbs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m1_n       (m1_n),
    .mreq_n     (mreq_n),
    .rd_n       (rd_n),
    .rfsh_n     (rfsh_n),
    .data_valid (data_valid)
);

// File: tb/fetch_bus_seq_tb.sv
module fetch_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_fetch = 1'b0;
    logic [15:0] addr_in = '0;
    logic [7:0]  data_in = 8'h11;
    logic        page_we = 1'b0;
    logic [7:0]  page_din = '0;
    logic        msb_din = 1'b0;
    logic [15:0] addr_out;
    logic        m1_n, mreq_n, rd_n, rfsh_n, data_valid;
    logic [7:0]  data_out;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;

    // reference model: kind 0 idle, 1 fetch, 2 read; t is the T state
    int          kind = 0;
    int          t = 0;
    int          row = 0;
    int          page = 0;
    int          hb = 0;
    int          maddr = 0;
    int          mdat = 0;
    bit          in_reset = 1;

    fetch_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_fetch(is_fetch),
        .addr_in(addr_in), .data_in(data_in), .page_we(page_we),
        .page_din(page_din), .msb_din(msb_din), .addr_out(addr_out),
        .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n), .rfsh_n(rfsh_n),
        .data_out(data_out), .data_valid(data_valid)
    );

    always #5 clk = ~clk;

    function automatic bit m_last();
        return (kind == 0) || (kind == 1 && t == 4) || (kind == 2 && t == 3);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            kind = 0; t = 0; row = 0; page = 0; hb = 0; maddr = 0; mdat = 0;
            in_reset = 1;
        end else begin
            bit last;
            in_reset = 0;
            last = m_last();
            if (t == 2 && kind != 0) mdat = int'(data_in);
            if (kind == 1 && t == 4) row = (row + 1) % 128;
            if (page_we) begin page = int'(page_din); hb = int'(msb_din); end
            if (last) begin
                if (start) begin
                    kind = is_fetch ? 1 : 2; t = 1; maddr = int'(addr_in);
                end else begin
                    kind = 0; t = 0;
                end
            end else t++;
        end
    end

    task automatic chk(string tag, string name, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, name, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int e_m1, e_mq, e_rd, e_rf, e_v, e_a;
            string ts, ta;
            e_m1 = 1; e_mq = 1; e_rd = 1; e_rf = 1; e_v = 0; e_a = maddr;
            ts = "R9"; ta = "R9";
            if (in_reset) begin ts = "R1"; ta = "R1"; end
            else if (kind == 1) begin
                if (t <= 2) begin
                    e_m1 = 0; e_mq = 0; e_rd = 0; ts = "R3";
                    ta = (t == 1) ? "R2" : "R3";
                end else begin
                    e_rf = 0; e_mq = (t == 3) ? 0 : 1; e_v = (t == 3) ? 1 : 0;
                    ts = "R5";
                    e_a = (page << 8) | (hb << 7) | row;
                end
            end else if (kind == 2) begin
                ts = "R7"; ta = (t == 1) ? "R2" : "R7";
                if (t <= 2) begin e_mq = 0; e_rd = 0; end
                else e_v = 1;
            end
            chk(ts, "m1_n", int'(m1_n), e_m1);
            chk(ts, "mreq_n", int'(mreq_n), e_mq);
            chk(ts, "rd_n", int'(rd_n), e_rd);
            chk(ts, "rfsh_n", int'(rfsh_n), e_rf);
            if (kind == 1 && t >= 3) begin
                chk("R6", "row", int'(addr_out[6:0]), e_a & 8'h7f);
                chk("R8", "page_hb", int'(addr_out[15:7]), e_a >> 7);
            end else begin
                chk(ta, "addr_out", int'(addr_out), e_a);
            end
            chk(in_reset ? "R1" : "R4", "data_out", int'(data_out), mdat);
            chk(in_reset ? "R1" : "R4", "data_valid", int'(data_valid), e_v);
        end
    end

    // data bus changes every clock
    initial begin
        forever begin
            @(posedge clk); #3;
            data_in = data_in * 8'd5 + 8'h3b;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic issue(bit f, logic [15:0] a);
        while (!m_last()) step();
        start = 1'b1; is_fetch = f; addr_in = a;
        step();
        start = 1'b0; addr_in = ~a;
    endtask

    task automatic load_page(logic [7:0] p, logic b);
        page_we = 1'b1; page_din = p; msb_din = b;
        step();
        page_we = 1'b0; page_din = ~p; msb_din = ~b;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        repeat (2) step();
        // R1: first fetch after reset shows row 0 with cleared page
        issue(1'b1, 16'h0101);
        repeat (5) step();
        load_page(8'hA5, 1'b1);
        issue(1'b1, 16'h1234);
        issue(1'b1, 16'h2000);
        issue(1'b0, 16'h3456);
        issue(1'b1, 16'h4321);
        issue(1'b0, 16'h0FFF);
        issue(1'b0, 16'h8001);
        repeat (4) step();
        // R2: mid-cycle request is ignored
        issue(1'b1, 16'h5555);
        start = 1'b1; is_fetch = 1'b0; addr_in = 16'h9999;
        step();
        start = 1'b0;
        repeat (6) step();
        issue(1'b0, 16'h7777);
        start = 1'b1; is_fetch = 1'b1; addr_in = 16'hAAAA;
        step();
        start = 1'b0;
        repeat (4) step();
        // R6: wrap the row counter; R8: page and held bit changes
        for (int i = 0; i < 130; i++) begin
            if (i == 60) load_page(8'h3C, 1'b0);
            if (i == 100) load_page(8'hC3, 1'b1);
            issue(1'b1, 16'(i * 257));
            if (i % 17 == 0) issue(1'b0, 16'(i * 31));
        end
        repeat (6) step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog: run hung actual=%0d expected=<100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule